// File: doc/BRIEF.md
# Receive Polarity Detect and Correct

This block works out whether the receive twisted pair has been wired with its two conductors swapped. It drives an invert control for the receive data slicer, so that the data decoded downstream always has the right sense. It never looks at waveforms. A qualifier upstream hands it one-cycle strobes that classify each link pulse and each frame ending. A strobe says "normal" or "reversed" as seen through the correction currently applied. A reversed strobe therefore means that the present setting is wrong.

Two independent evidence counters gather reversed observations, one for link pulses and one for frame endings. When either counter reaches its limit, the invert control toggles and both counters start again. Any observation of correct polarity clears both counters. Link pulses count only while link testing is enabled. While the link is down, a timer watches for silence. If no receive activity or strobe arrives for the hold interval, the polarity returns to the non-inverted default. No input can switch the correction off.

Top module: `rx_polarity_fix`

## Requirements
- R1: After reset, `rx_invert` and `pol_flipped` are 0 and both evidence counters are empty.
- R2: With `link_test_en` high, PULSE_LIMIT (default 8) consecutive `lp_rev` strobes toggle `rx_invert` on the clock edge that samples the last one. One strobe fewer leaves it unchanged.
- R3: FRAME_LIMIT (default 4) consecutive `eof_rev` strobes toggle `rx_invert` on the edge that samples the last one. One strobe fewer leaves it unchanged.
- R4: A correct-polarity event clears both counters. Such an event is an `eof_norm` strobe, or an `lp_norm` strobe while `link_test_en` is high. After it, a full run of reversed strobes is again needed to toggle.
- R5: While `link_test_en` is low, `lp_norm` and `lp_rev` have no effect. They neither advance nor clear the pulse counter, and they do not clear the frame counter.
- R6: While `link_fail` is high, `rx_invert` returns to 0 on the HOLD_CYCLES-th consecutive clock with no `rx_active` and no strobe. Both counters are cleared at that point. Any activity or strobe restarts the interval. `link_fail` low stops the timer.
- R7: A toggle clears both counters. The evidence that follows is judged against the new setting, so a second toggle needs a fresh full run.
- R8: In one cycle, a correct-polarity event wins over every reversed strobe in that cycle. Reversed pulse and frame strobes that arrive together each advance their own counter.
- R9: `pol_flipped` always equals `rx_invert`.
- R10: The two counters are independent. PULSE_LIMIT-1 reversed pulses mixed with FRAME_LIMIT-1 reversed frame endings cause no toggle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, also the fallback timebase |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_norm | input | 1 | Link pulse seen with correct polarity (1-cycle strobe) |
| lp_rev | input | 1 | Link pulse seen with reversed polarity |
| eof_norm | input | 1 | Frame ended with normal start-of-idle |
| eof_rev | input | 1 | Frame ended with reversed start-of-idle |
| link_test_en | input | 1 | Link test enabled; gates the link pulse strobes |
| link_fail | input | 1 | Link is in the fail state |
| rx_active | input | 1 | Receive activity present |
| rx_invert | output | 1 | Invert control to the slicer, 1 = swap |
| pol_flipped | output | 1 | Status: polarity currently corrected |

## Verification
The counters are hidden, so a wrong count shows up only as a toggle that comes one strobe early or late, or that never comes. The bench therefore sweeps run lengths around each limit and samples the output one edge after every strobe. It also places the clearing event at every position within a run. A fault in the fallback timer shows up only as `rx_invert` falling one cycle off the HOLD_CYCLES boundary. For this reason the silence interval is checked at its last edge and at the edge just before it, both with and without a restart.

// File: rtl/pol_pkg.sv
package pol_pkg;
   typedef struct packed {
      logic good;     // correct-polarity evidence this cycle
      logic lp_bad;   // reversed link pulse counted this cycle
      logic ef_bad;   // reversed frame ending counted this cycle
      logic any;      // any qualified strobe this cycle
   } pol_evt_t;

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/pol_event_qual.sv
module pol_event_qual
   import pol_pkg::*;
#(
   parameter bit GOOD_WINS = 1'b1
) (
   input  logic     lp_norm,
   input  logic     lp_rev,
   input  logic     eof_norm,
   input  logic     eof_rev,
   input  logic     link_test_en,
   output pol_evt_t evt
);
   logic lp_ok;
   logic lp_bad_raw;
   logic good_raw;

   always_comb begin
      lp_ok      = lp_norm & link_test_en;
      lp_bad_raw = lp_rev & link_test_en;
      good_raw   = lp_ok | eof_norm;
   end

   generate
      if (GOOD_WINS) begin : g_good_wins
         always_comb begin
            evt.good   = good_raw;
            evt.lp_bad = lp_bad_raw & ~good_raw;
            evt.ef_bad = eof_rev & ~good_raw;
         end
      end else begin : g_bad_wins
         always_comb begin
            evt.good   = good_raw & ~(lp_bad_raw | eof_rev);
            evt.lp_bad = lp_bad_raw;
            evt.ef_bad = eof_rev;
         end
      end
   endgenerate

   assign evt.any = lp_ok | lp_bad_raw | eof_norm | eof_rev;
endmodule

// File: rtl/pol_evidence_ctr.sv
module pol_evidence_ctr
   import pol_pkg::*;
#(
   parameter int unsigned LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic hit
);
   localparam int unsigned W = cnt_width(LIMIT);
   localparam logic [W-1:0] LAST = W'(LIMIT - 1);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("pol_evidence_ctr: LIMIT must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   assign hit = inc & (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr || hit) begin
         cnt_q <= '0;
      end else if (inc && (cnt_q < LAST)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/pol_fallback_timer.sv
module pol_fallback_timer
   import pol_pkg::*;
#(
   parameter int unsigned HOLD_CYCLES = 1_120_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic link_fail,
   input  logic activity,
   output logic expire
);
   localparam int unsigned W = cnt_width(HOLD_CYCLES);
   localparam logic [W-1:0] LAST = W'(HOLD_CYCLES - 1);
   localparam logic [W-1:0] TOP  = W'(HOLD_CYCLES);

   generate
      if (HOLD_CYCLES < 1) begin : g_bad_hold
         $error("pol_fallback_timer: HOLD_CYCLES must be at least 1");
      end
   endgenerate

   logic [W-1:0] tmr_q;
   logic         quiet;

   assign quiet  = link_fail & ~activity;
   assign expire = quiet & (tmr_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tmr_q <= '0;
      end else if (!quiet) begin
         tmr_q <= '0;
      end else if (tmr_q != TOP) begin
         tmr_q <= tmr_q + 1'b1;
      end
   end
endmodule

// File: rtl/rx_polarity_fix.sv
module rx_polarity_fix
   import pol_pkg::*;
#(
   parameter int unsigned PULSE_LIMIT = 8,
   parameter int unsigned FRAME_LIMIT = 4,
   parameter int unsigned HOLD_CYCLES = 1_120_000,
   parameter bit          GOOD_WINS   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lp_norm,
   input  logic lp_rev,
   input  logic eof_norm,
   input  logic eof_rev,
   input  logic link_test_en,
   input  logic link_fail,
   input  logic rx_active,
   output logic rx_invert,
   output logic pol_flipped
);
   localparam int unsigned NCH = 2;

   pol_evt_t evt;
   logic [NCH-1:0] ch_inc;
   logic [NCH-1:0] ch_hit;
   logic           flip;
   logic           expire;
   logic           clr_all;
   logic           inv_q;

   pol_event_qual #(.GOOD_WINS(GOOD_WINS)) u_qual (
      .lp_norm      (lp_norm),
      .lp_rev       (lp_rev),
      .eof_norm     (eof_norm),
      .eof_rev      (eof_rev),
      .link_test_en (link_test_en),
      .evt          (evt)
   );

   assign ch_inc = {evt.ef_bad, evt.lp_bad};

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         localparam int unsigned LIM = (c == 0) ? PULSE_LIMIT : FRAME_LIMIT;
         pol_evidence_ctr #(.LIMIT(LIM)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_all),
            .inc   (ch_inc[c]),
            .hit   (ch_hit[c])
         );
      end
   endgenerate

   pol_fallback_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_fall (
      .clk       (clk),
      .rst_n     (rst_n),
      .link_fail (link_fail),
      .activity  (rx_active | evt.any),
      .expire    (expire)
   );

   assign flip    = |ch_hit;
   assign clr_all = evt.good | flip | expire;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         inv_q <= 1'b0;
      end else if (expire) begin
         inv_q <= 1'b0;
      end else if (flip) begin
         inv_q <= ~inv_q;
      end
   end

   assign rx_invert   = inv_q;
   assign pol_flipped = inv_q;
endmodule

// File: rtl/rx_polarity_fix_chk.sv
module rx_polarity_fix_chk (
   input logic clk,
   input logic rst_n,
   input logic lp_norm,
   input logic lp_rev,
   input logic eof_norm,
   input logic eof_rev,
   input logic link_test_en,
   input logic link_fail,
   input logic rx_invert,
   input logic pol_flipped
);
   // R9: status tracks the invert control
   p_status_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pol_flipped == rx_invert);

   // R4: correct-polarity evidence never moves the invert control
   p_good_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((lp_norm && link_test_en) || eof_norm) |=> $stable(rx_invert));

   // R5: with link test off and no frame strobe or link fail, nothing changes
   p_lp_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!link_test_en && !eof_norm && !eof_rev && !link_fail) |=> $stable(rx_invert));

   // R2: a rise needs a reversed strobe one cycle earlier
   p_rise_needs_rev_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_invert) |-> $past((lp_rev && link_test_en) || eof_rev));

   // R6: a fall comes only from reversed evidence or from the link-fail fallback
   p_fall_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_invert) |-> $past(link_fail || eof_rev || (lp_rev && link_test_en)));
endmodule

bind rx_polarity_fix rx_polarity_fix_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .lp_norm      (lp_norm),
   .lp_rev       (lp_rev),
   .eof_norm     (eof_norm),
   .eof_rev      (eof_rev),
   .link_test_en (link_test_en),
   .link_fail    (link_fail),
   .rx_invert    (rx_invert),
   .pol_flipped  (pol_flipped)
);

// File: tb/sim_rx_polarity_fix.sv
module sim_rx_polarity_fix;
   localparam int PL = 8;
   localparam int FL = 4;
   localparam int HOLD = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lp_norm = 1'b0, lp_rev = 1'b0, eof_norm = 1'b0, eof_rev = 1'b0;
   logic link_test_en = 1'b1, link_fail = 1'b0, rx_active = 1'b0;
   logic rx_invert, pol_flipped;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   rx_polarity_fix #(.PULSE_LIMIT(PL), .FRAME_LIMIT(FL), .HOLD_CYCLES(HOLD)) u0 (
      .clk(clk), .rst_n(rst_n), .lp_norm(lp_norm), .lp_rev(lp_rev),
      .eof_norm(eof_norm), .eof_rev(eof_rev), .link_test_en(link_test_en),
      .link_fail(link_fail), .rx_active(rx_active),
      .rx_invert(rx_invert), .pol_flipped(pol_flipped));

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: rx_invert actual %0b expected %0b", tag, act, exp);
      end
      if (pol_flipped !== act) begin
         errors++;
         $display("FAIL R9: pol_flipped actual %0b expected %0b", pol_flipped, act);
      end
   endtask

   // apply one cycle of strobes; returns after the sampling edge, at a negedge
   task automatic drive(input logic a, input logic b, input logic c, input logic d);
      lp_norm = a; lp_rev = b; eof_norm = c; eof_rev = d;
      @(negedge clk);
      lp_norm = 0; lp_rev = 0; eof_norm = 0; eof_rev = 0;
   endtask

   task automatic do_reset();
      rst_n = 0; link_test_en = 1; link_fail = 0; rx_active = 0;
      @(negedge clk); @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      do_reset();
      chk("R1 reset", rx_invert, 1'b0);

      // R2: sweep run lengths of reversed pulses
      for (int n = 1; n <= PL + 2; n++) begin
         do_reset();
         for (int i = 0; i < n; i++) drive(0, 1, 0, 0);
         chk("R2 pulse run", rx_invert, (n >= PL));
      end

      // R3: sweep run lengths of reversed frame endings
      for (int n = 1; n <= FL + 2; n++) begin
         do_reset();
         for (int i = 0; i < n; i++) drive(0, 0, 0, 1);
         chk("R3 frame run", rx_invert, (n >= FL));
      end

      // R4: a clearing event at every position restarts the pulse run
      for (int k = 0; k < PL; k++) begin
         for (int kind = 0; kind < 2; kind++) begin
            do_reset();
            for (int i = 0; i < k; i++) drive(0, 1, 0, 0);
            if (kind == 0) drive(1, 0, 0, 0); else drive(0, 0, 1, 0);
            for (int i = 0; i < PL - 1; i++) drive(0, 1, 0, 0);
            chk("R4 cleared run", rx_invert, 1'b0);
            drive(0, 1, 0, 0);
            chk("R4 full run after clear", rx_invert, 1'b1);
         end
      end
      // R4: a normal pulse clears the frame counter too
      do_reset();
      for (int i = 0; i < FL - 1; i++) drive(0, 0, 0, 1);
      drive(1, 0, 0, 0);
      drive(0, 0, 0, 1);
      chk("R4 frame cleared by pulse", rx_invert, 1'b0);

      // R5: link test off, pulse strobes ignored
      do_reset();
      link_test_en = 0;
      for (int i = 0; i < PL + 3; i++) drive(0, 1, 0, 0);
      chk("R5 rev pulses ignored", rx_invert, 1'b0);
      for (int i = 0; i < FL - 1; i++) drive(0, 0, 0, 1);
      drive(1, 0, 0, 0);
      drive(0, 0, 0, 1);
      chk("R5 norm pulse does not clear frames", rx_invert, 1'b1);

      // R7: after a flip, a second toggle needs a fresh full run
      do_reset();
      for (int i = 0; i < PL; i++) drive(0, 1, 0, 0);
      for (int i = 0; i < PL - 1; i++) drive(0, 1, 0, 0);
      chk("R7 no early second toggle", rx_invert, 1'b1);
      drive(0, 1, 0, 0);
      chk("R7 second toggle", rx_invert, 1'b0);
      do_reset();
      for (int i = 0; i < FL - 1; i++) drive(0, 0, 0, 1);
      for (int i = 0; i < PL; i++) drive(0, 1, 0, 0);
      drive(0, 0, 0, 1);
      chk("R7 frame count cleared by flip", rx_invert, 1'b1);

      // R8: same-cycle priority and joint counting
      do_reset();
      for (int i = 0; i < PL - 1; i++) drive(0, 1, 0, 0);
      drive(0, 1, 1, 0);
      chk("R8 good frame beats rev pulse", rx_invert, 1'b0);
      do_reset();
      for (int i = 0; i < FL - 1; i++) drive(0, 0, 0, 1);
      drive(1, 0, 0, 1);
      chk("R8 good pulse beats rev frame", rx_invert, 1'b0);
      do_reset();
      for (int i = 0; i < FL - 1; i++) drive(0, 1, 0, 1);
      chk("R8 joint strobes below limit", rx_invert, 1'b0);
      drive(0, 1, 0, 1);
      chk("R8 joint strobes reach frame limit", rx_invert, 1'b1);

      // R10: independent counters
      do_reset();
      for (int i = 0; i < PL - 1; i++) drive(0, 1, 0, 0);
      for (int i = 0; i < FL - 1; i++) drive(0, 0, 0, 1);
      chk("R10 mixed evidence no toggle", rx_invert, 1'b0);

      // R6: fallback timing
      do_reset();
      for (int i = 0; i < PL; i++) drive(0, 1, 0, 0);
      link_fail = 1;
      for (int i = 0; i < HOLD - 1; i++) drive(0, 0, 0, 0);
      chk("R6 one cycle before expiry", rx_invert, 1'b1);
      drive(0, 0, 0, 0);
      chk("R6 expiry restores default", rx_invert, 1'b0);
      // restart by activity
      link_fail = 0;
      do_reset();
      for (int i = 0; i < PL; i++) drive(0, 1, 0, 0);
      link_fail = 1;
      for (int i = 0; i < HOLD - 4; i++) drive(0, 0, 0, 0);
      rx_active = 1; drive(0, 0, 0, 0); rx_active = 0;
      for (int i = 0; i < HOLD - 1; i++) drive(0, 0, 0, 0);
      chk("R6 activity restarts interval", rx_invert, 1'b1);
      drive(0, 0, 0, 0);
      chk("R6 expiry after restart", rx_invert, 0);
      // expiry also clears counters
      link_fail = 0;
      do_reset();
      for (int i = 0; i < PL - 1; i++) drive(0, 1, 0, 0);
      link_fail = 1;
      for (int i = 0; i < HOLD; i++) drive(0, 0, 0, 0);
      link_fail = 0;
      drive(0, 1, 0, 0);
      chk("R6 counters cleared by expiry", rx_invert, 1'b0);
      // no timer while link is good
      for (int i = 0; i < PL - 1; i++) drive(0, 1, 0, 0);
      for (int i = 0; i < 3 * HOLD; i++) drive(0, 0, 0, 0);
      chk("R6 no fallback with link up", rx_invert, 1'b1);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule